// File: doc/BRIEF.md
# Serial-In Shift Register with Output Latch

This block accepts a serial bit stream into a chain of shift stages. On command, it copies the whole chain into a holding register that feeds a parallel output bus. The shift stages and the holding register advance on two separate strobes. Because both strobes are ordinary inputs sampled on the system clock, the block reacts to their rising edges and stays fully synchronous with that clock.

The parallel outputs can be taken off the bus. Instead of internal high-impedance values, the block supplies a drive-enable flag alongside the value bus. The last shift stage is always driven onto a serial output. That output can feed the serial input of a further instance, so longer registers can be built from several blocks.

An active-low clear empties only the shift stages, and it does so without waiting for a clock edge. It leaves the holding register and the parallel bus untouched.

Top module: `serial_latch_shifter`

## Requirements
- R1: While and after the synchronous active-high `rst`, all shift stages, the holding register, `ser_out`, `par_q` and `par_drive` are 0.
- R2: A rising edge of `shift_strb` is a cycle in which it is sampled 1 after being sampled 0 on the previous clock. On that clock edge, `ser_in` enters stage 0 and stage i moves to stage i+1. The result is visible right after that edge.
- R3: Holding `shift_strb` high for several cycles produces exactly one shift.
- R4: A rising edge of `latch_strb`, defined in the same way, copies all stages in parallel into the holding register. Stage i goes to `par_q[i]`.
- R5: Without a rising edge of `latch_strb`, the holding register keeps its value, including while shifts take place.
- R6: While `clr_n` is low, all shift stages are 0 and shift edges are ignored. `ser_out` goes to 0 at once, without a clock edge. The holding register is not affected.
- R7: `par_drive` is the registered inverse of `oe_n`, with one cycle of latency. While `par_drive` is 1, `par_q` shows the holding register; while it is 0, `par_q` is all zero.
- R8: `ser_out` always equals the last stage (N-1), whatever the value of `oe_n`.
- R9: When rising edges of both strobes fall in the same cycle, the holding register receives the stage values from before that shift.
- R10: When the `ser_out` of one instance feeds the `ser_in` of a second instance and both share their strobes, the pair behaves as a single 2N-stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| ser_in | input | 1 | Serial data input into stage 0 |
| shift_strb | input | 1 | Shift strobe, acts on its rising edge |
| latch_strb | input | 1 | Transfer strobe, acts on its rising edge |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_out | output | 1 | Last shift stage, always driven |
| par_q | output | N | Parallel value bus from the holding register |
| par_drive | output | 1 | 1 when par_q is to be driven, 0 for high impedance |

## Verification
On every clock cycle, the assertions check the single-step shift relation, the parallel capture on a transfer edge and the stability of the holding register between transfers. They also check that the serial output reads 0 while the clear is low, and the one-cycle tracking of the drive flag. Other behaviours can only be shown by the bench's scenarios. These are: the serial output dropping before any clock edge when the clear falls, a strobe held high giving exactly one shift, every 8-bit pattern passing through intact, and two chained instances acting as one 16-stage register.

// File: rtl/slsh_pkg.sv
package slsh_pkg;
  // index of each strobe in the edge-detector vector
  localparam int unsigned STB_SHIFT = 0;
  localparam int unsigned STB_LATCH = 1;
  localparam int unsigned STB_COUNT = 2;

  typedef struct packed {
    logic latch;
    logic shift;
  } strobe_evt_t;
endpackage

// File: rtl/slsh_edge_detect.sv
module slsh_edge_detect #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  // the previous level is tracked in every cycle, reset included
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      prev_q[i] <= level[i];
    end
    assign rise[i] = level[i] & ~prev_q[i];
  end
endmodule

// File: rtl/slsh_shift_chain.sv
module slsh_shift_chain #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         advance,
  input  logic         din,
  output logic [N-1:0] stages
);
  logic [N-1:0] sr_q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = din;
    end else begin : g_body
      assign d = sr_q[i-1];
    end
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)       sr_q[i] <= 1'b0;
      else if (rst)     sr_q[i] <= 1'b0;
      else if (advance) sr_q[i] <= d;
    end
  end

  assign stages = sr_q;
endmodule

// File: rtl/slsh_hold_stage.sv
module slsh_hold_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [N-1:0] stages,
  input  logic         oe_n,
  output logic [N-1:0] hold,
  output logic [N-1:0] par_q,
  output logic         par_drive
);
  logic [N-1:0] hold_q;
  logic         drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      if (capture) hold_q <= stages;
      drive_q <= ~oe_n;
    end
  end

  assign hold      = hold_q;
  assign par_drive = drive_q;
  assign par_q     = drive_q ? hold_q : '0;
endmodule

// File: rtl/serial_latch_shifter.sv
module serial_latch_shifter
  import slsh_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         ser_in,
  input  logic         shift_strb,
  input  logic         latch_strb,
  input  logic         oe_n,
  output logic         ser_out,
  output logic [N-1:0] par_q,
  output logic         par_drive
);
  logic [STB_COUNT-1:0] levels;
  logic [STB_COUNT-1:0] rises;
  strobe_evt_t          evt;
  logic [N-1:0]         sr_q;
  logic [N-1:0]         hold_q;

  assign levels[STB_SHIFT] = shift_strb;
  assign levels[STB_LATCH] = latch_strb;

  slsh_edge_detect #(.W(STB_COUNT)) u_edges (
    .clk   (clk),
    .level (levels),
    .rise  (rises)
  );

  assign evt.shift = rises[STB_SHIFT];
  assign evt.latch = rises[STB_LATCH];

  slsh_shift_chain #(.N(N)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .advance (evt.shift),
    .din     (ser_in),
    .stages  (sr_q)
  );

  slsh_hold_stage #(.N(N)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .capture   (evt.latch),
    .stages    (sr_q),
    .oe_n      (oe_n),
    .hold      (hold_q),
    .par_q     (par_q),
    .par_drive (par_drive)
  );

  assign ser_out = sr_q[N-1];
endmodule

// File: rtl/slsh_checker.sv
module slsh_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_n,
  input logic         ser_in,
  input logic         shift_strb,
  input logic         latch_strb,
  input logic         oe_n,
  input logic         ser_out,
  input logic         par_drive,
  input logic [N-1:0] stages,
  input logic [N-1:0] hold
);
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(shift_strb) && clr_n) |=>
      (!clr_n || stages == {$past(stages[N-2:0]), $past(ser_in)}));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_strb) |=> hold == $past(stages));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !$rose(latch_strb) |=> $stable(hold));

  assert_clear_low_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (ser_out == 1'b0));

  assert_drive_track_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> par_drive == !$past(oe_n));

  assert_serial_tap_R8: assert property (@(posedge clk) disable iff (rst)
    ser_out == stages[N-1]);
endmodule

bind serial_latch_shifter slsh_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_n      (clr_n),
  .ser_in     (ser_in),
  .shift_strb (shift_strb),
  .latch_strb (latch_strb),
  .oe_n       (oe_n),
  .ser_out    (ser_out),
  .par_drive  (par_drive),
  .stages     (sr_q),
  .hold       (hold_q)
);

// File: tb/serial_latch_shifter_tb.sv
module serial_latch_shifter_tb;
  localparam int unsigned N = 8;
  localparam int unsigned M = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1;
  logic ser_in = 1'b0;
  logic shift = 1'b0;
  logic latch = 1'b0;
  logic oe_n = 1'b1;

  logic         so_h, so_t, drv_h, drv_t;
  logic [N-1:0] pq_h, pq_t;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model of the chained pair: low half = head, high half = tail
  logic [M-1:0] m_sr = '0;
  logic [M-1:0] m_hold = '0;
  logic         m_drive = 1'b0;
  logic         p_shift = 1'b0;
  logic         p_latch = 1'b0;

  always #5 clk = ~clk;

  serial_latch_shifter #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ser_in(ser_in),
    .shift_strb(shift), .latch_strb(latch), .oe_n(oe_n),
    .ser_out(so_h), .par_q(pq_h), .par_drive(drv_h)
  );

  serial_latch_shifter #(.N(N)) u_tail (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ser_in(so_h),
    .shift_strb(shift), .latch_strb(latch), .oe_n(oe_n),
    .ser_out(so_t), .par_q(pq_t), .par_drive(drv_t)
  );

  task automatic cyc();
    logic rs, rl;
    @(posedge clk);
    rs = shift && !p_shift;
    rl = latch && !p_latch;
    if (rst) begin
      m_sr = '0; m_hold = '0; m_drive = 1'b0;
    end else begin
      if (rl) m_hold = m_sr;
      if (!clr_n) m_sr = '0;
      else if (rs) m_sr = {m_sr[M-2:0], ser_in};
      m_drive = !oe_n;
    end
    p_shift = shift;
    p_latch = latch;
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [2*N+3:0] act, exp;
    act = {pq_t, pq_h, drv_t, drv_h, so_t, so_h};
    exp = {(m_drive ? m_hold[M-1:N] : {N{1'b0}}),
           (m_drive ? m_hold[N-1:0] : {N{1'b0}}),
           m_drive, m_drive, m_sr[M-1], m_sr[N-1]};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b, string req);
    ser_in = b; shift = 1'b1; cyc(); check_all(req);
    shift = 1'b0; cyc(); check_all(req);
  endtask

  task automatic do_latch(string req);
    latch = 1'b1; cyc(); check_all(req);
    latch = 1'b0; cyc(); check_all(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    check_all("R1 during reset");
    rst = 1'b0;
    cyc();
    check_all("R1 after reset");
    oe_n = 1'b0;
    cyc();
    check_all("R7 drive enabled");

    // R2 R4 R10: every 8-bit pattern, MSB first, through the chained pair
    for (int v = 0; v < 256; v++) begin
      for (int b = N - 1; b >= 0; b--) shift_bit(v[b], "R2 R10 shift");
      check_all("R5 hold kept during shifts");
      do_latch("R4 R10 transfer");
      n_chk++;
      if (pq_h !== v[N-1:0]) begin
        n_bad++;
        $display("FAIL R4 pattern: actual %h expected %h", pq_h, v[N-1:0]);
      end
    end

    // R3: strobe held high shifts once
    ser_in = 1'b1; shift = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); check_all("R3 held strobe"); end
    shift = 1'b0; cyc(); check_all("R3 release");

    // R7 R8: outputs released, serial output unaffected
    oe_n = 1'b1;
    cyc(); check_all("R7 released");
    shift_bit(1'b0, "R8 serial with oe_n high");
    shift_bit(1'b1, "R8 serial with oe_n high");
    do_latch("R7 latch while released");
    oe_n = 1'b0;
    cyc(); check_all("R7 re-enabled");

    // R9: simultaneous shift and transfer edges
    for (int k = 0; k < 3; k++) begin
      ser_in = k[0]; shift = 1'b1; latch = 1'b1;
      cyc(); check_all("R9 simultaneous");
      shift = 1'b0; latch = 1'b0;
      cyc(); check_all("R9 simultaneous");
    end

    // R6: asynchronous clear
    for (int k = 0; k < M; k++) shift_bit(1'b1, "R6 fill");
    do_latch("R6 fill latch");
    #2 clr_n = 1'b0; m_sr = '0;
    #1 check_all("R6 clear without edge");
    shift_bit(1'b1, "R6 shift ignored during clear");
    cyc(); check_all("R6 hold untouched");
    @(negedge clk) clr_n = 1'b1;
    cyc(); check_all("R6 after release");
    do_latch("R6 cleared stages transferred");
    shift_bit(1'b1, "R6 shift resumes");

    // R1: reset in mid operation
    rst = 1'b1; cyc(); check_all("R1 reset mid run");
    rst = 1'b0; cyc(); check_all("R1 after second reset");

    finish_run();
  end
endmodule